// File: doc/BRIEF.md
# Infrared Keypad Command Transmitter

This block turns four active-high key inputs into a repeating infrared command on one carrier-modulated output pin. While a key is held, it sends a frame for that key, pauses for an idle gap, and sends the frame again for as long as the same key remains pressed. When the key is released, the frame in progress is finished, the idle gap runs out, and the block goes quiet.

A frame holds a 3-bit key code followed by the bitwise inverse of that code. Every symbol is a fixed-length carrier burst. The symbol's meaning is carried only by the silent gap that follows the burst. The block contains its own carrier divider, a restartable 100 µs protocol timebase and the frame sequencer. The parameter `CAR_HALF` sets the number of clock cycles between carrier toggles. The parameter `TICK_DIV` sets the number of clock cycles in one protocol tick. At the defaults (105 and 800), an 8 MHz clock gives a carrier of about 38 kHz and 100 µs ticks.

Top module: `ir_frame_tx`

## Requirements
- R1: While reset is asserted and right after it is released, `ir_o` and `busy_o` are low.
- R2: A burst starts with `ir_o` high. The output then toggles every `CAR_HALF` cycles. The carrier phase restarts at every burst, so each burst has the same number of high cycles.
- R3: Outside a burst, `ir_o` is driven low, and it returns low at the end of every burst.
- R4: One tick is `TICK_DIV` clock cycles. Every burst lasts 6 ticks. The silent gap after a burst lasts 30 ticks for the header, 10 ticks for a logic 1 and 20 ticks for a logic 0.
- R5: A frame is sent in this order: header, then code bits 0, 1 and 2 (bit 0 first), then the inverses of bits 0, 1 and 2 in the same order, then a stop burst with no gap of its own.
- R6: Key codes are 3'b001 for key 0, 3'b100 for key 1, 3'b101 for key 2 and 3'b111 for key 3. When several keys are high, the lowest-numbered key wins.
- R7: After the stop burst the block waits 200 ticks. It then samples the key that started the frame. If that key is still high, the next header starts 206 ticks after the start of the stop burst; if not, the block goes idle.
- R8: The key index and its code are captured when the first frame starts. Input changes during the frames, including a press of a higher-priority key, do not change the frame being sent or the code of its repeats.
- R9: If the key is released part-way through a frame, the frame is still sent in full, stop burst included.
- R10: `busy_o` rises together with the first header burst. It falls 206 ticks after the last stop burst begins.
- R11: The keys pass through a two-flop synchronizer. With no key high, the block stays idle: `ir_o` low and `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| key_i | input | 4 | Active-high key inputs; index 0 has the highest priority |
| ir_o | output | 1 | Carrier-modulated IR drive, low when no burst is active |
| busy_o | output | 1 | High from the first header burst until the final idle gap ends |

## Verification
The bench builds the block with `CAR_HALF` = 2 and `TICK_DIV` = 8. With these values a burst is 48 cycles containing exactly 24 high cycles, and the 200-tick repeat gap is only 1600 cycles. This makes multi-frame repeats, every key code, a priority clash and a mid-frame press of a higher-priority key affordable in one run. Burst-to-burst spacing, high-cycle counts per burst and the fall time of `busy_o` are all measured in exact clock cycles.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

  localparam int NKEY     = 4;
  localparam int KI_W     = $clog2(NKEY);
  localparam int CODE_W   = 3;
  localparam int TK_W     = 8;

  localparam int BURST_TK = 6;
  localparam int HDR_TK   = 30;
  localparam int ONE_TK   = 10;
  localparam int ZERO_TK  = 20;
  localparam int REST_TK  = 200;
  localparam int LAST_SYM = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MARK,
    ST_SPACE,
    ST_STOP,
    ST_REST
  } irtx_st_e;

  function automatic logic [CODE_W-1:0] key_code(input logic [KI_W-1:0] idx);
    case (idx)
      2'd0:    key_code = 3'b001;
      2'd1:    key_code = 3'b100;
      2'd2:    key_code = 3'b101;
      default: key_code = 3'b111;
    endcase
  endfunction

  function automatic logic sym_bit(input logic [CODE_W-1:0] code, input logic [2:0] sym);
    case (sym)
      3'd1:    sym_bit = code[0];
      3'd2:    sym_bit = code[1];
      3'd3:    sym_bit = code[2];
      3'd4:    sym_bit = ~code[0];
      3'd5:    sym_bit = ~code[1];
      3'd6:    sym_bit = ~code[2];
      default: sym_bit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/irtx_sync.sv
module irtx_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d_i;
      hold_q <= meta_q;
    end
  end

  assign q_o = hold_q;

endmodule

// File: rtl/irtx_tick.sv
module irtx_tick #(
  parameter int DIV = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);

  localparam int CW = $clog2(DIV + 1);
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr_i || cnt_q == TOP) cnt_d = '0;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == TOP);

  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP); // R4

endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
  parameter int HALF = 105
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic ir_o
);

  localparam int DW = $clog2(HALF + 1);
  localparam logic [DW-1:0] TOP = DW'(HALF - 1);

  logic [DW-1:0] div_q, div_d;
  logic          lvl_q, lvl_d;

  always_comb begin
    div_d = div_q;
    lvl_d = lvl_q;
    if (!en_i) begin
      div_d = '0;
      lvl_d = 1'b1;
    end else if (div_q == TOP) begin
      div_d = '0;
      lvl_d = ~lvl_q;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      lvl_q <= 1'b1;
    end else begin
      div_q <= div_d;
      lvl_q <= lvl_d;
    end
  end

  assign ir_o = en_i & lvl_q;

  AST_CAR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i) && $past(div_q) == TOP) |-> (lvl_q != $past(lvl_q))); // R2
  AST_CAR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_i) |-> ir_o); // R2

endmodule

// File: rtl/ir_frame_tx.sv
module ir_frame_tx
  import irtx_pkg::*;
#(
  parameter int CAR_HALF = 105,
  parameter int TICK_DIV = 800
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NKEY-1:0] key_i,
  output logic            ir_o,
  output logic            busy_o
);

  logic [1:0] rs_q;
  logic       rst_ln;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ln = rs_q[1];

  logic [NKEY-1:0] ksync;

  irtx_sync #(.W(NKEY)) u_sync (
    .clk   (clk),
    .rst_n (rst_ln),
    .d_i   (key_i),
    .q_o   (ksync)
  );

  irtx_st_e          st_q, st_d;
  logic [2:0]        sym_q, sym_d;
  logic [TK_W-1:0]   tk_q, tk_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [KI_W-1:0]   sel_q, sel_d;
  logic [KI_W-1:0]   pick;
  logic [TK_W-1:0]   plen;
  logic              tick, done, clr, burst_on;

  irtx_tick #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_ln),
    .clr_i  (clr),
    .tick_o (tick)
  );

  always_comb begin
    pick = '0;
    for (int i = NKEY - 1; i >= 0; i--) begin
      if (ksync[i]) pick = KI_W'(i);
    end
  end

  always_comb begin
    case (st_q)
      ST_MARK, ST_STOP: plen = TK_W'(BURST_TK);
      ST_REST:          plen = TK_W'(REST_TK);
      ST_SPACE: begin
        if (sym_q == 3'd0)               plen = TK_W'(HDR_TK);
        else if (sym_bit(code_q, sym_q)) plen = TK_W'(ONE_TK);
        else                             plen = TK_W'(ZERO_TK);
      end
      default:          plen = TK_W'(1);
    endcase
  end

  assign done = tick && (tk_q == plen - 1'b1);
  assign clr  = (st_q == ST_IDLE) || done;

  always_comb begin
    st_d   = st_q;
    sym_d  = sym_q;
    code_d = code_q;
    sel_d  = sel_q;
    if (done)      tk_d = '0;
    else if (tick) tk_d = tk_q + 1'b1;
    else           tk_d = tk_q;
    case (st_q)
      ST_IDLE: begin
        tk_d = '0;
        if (|ksync) begin
          st_d   = ST_MARK;
          sym_d  = 3'd0;
          sel_d  = pick;
          code_d = key_code(pick);
        end
      end
      ST_MARK:  if (done) st_d = ST_SPACE;
      ST_SPACE: begin
        if (done) begin
          if (sym_q == 3'(LAST_SYM)) st_d = ST_STOP;
          else begin
            st_d  = ST_MARK;
            sym_d = sym_q + 1'b1;
          end
        end
      end
      ST_STOP:  if (done) st_d = ST_REST;
      ST_REST: begin
        if (done) begin
          if (ksync[sel_q]) begin
            st_d  = ST_MARK;
            sym_d = 3'd0;
          end else begin
            st_d  = ST_IDLE;
          end
        end
      end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      st_q   <= ST_IDLE;
      sym_q  <= '0;
      tk_q   <= '0;
      code_q <= '0;
      sel_q  <= '0;
    end else begin
      st_q   <= st_d;
      sym_q  <= sym_d;
      tk_q   <= tk_d;
      code_q <= code_d;
      sel_q  <= sel_d;
    end
  end

  assign burst_on = (st_q == ST_MARK) || (st_q == ST_STOP);
  assign busy_o   = (st_q != ST_IDLE);

  irtx_carrier #(.HALF(CAR_HALF)) u_car (
    .clk   (clk),
    .rst_n (rst_ln),
    .en_i  (burst_on),
    .ir_o  (ir_o)
  );

  AST_DARK_IDLE: assert property (@(posedge clk) disable iff (!rst_ln)
    !busy_o |-> !ir_o); // R3
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_ln)
    (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |-> $stable(code_q)); // R8
  AST_SYM_RANGE: assert property (@(posedge clk) disable iff (!rst_ln)
    sym_q <= 3'(LAST_SYM)); // R5
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_ln)
    $rose(busy_o) |-> (st_q == ST_MARK && sym_q == 3'd0)); // R10

endmodule

// File: tb/sim_ir_frame_tx.sv
module sim_ir_frame_tx;

  localparam int CH = 2;
  localparam int TD = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] key;
  logic       ir_o, busy_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  int per_q[$];
  int hi_q[$];

  int  sil = 1000;
  int  hi_cnt = 0;
  int  last_start = 0;
  int  nstarts = 0;
  bit  have_prev = 0;
  bit  flush_req = 0;

  ir_frame_tx #(.CAR_HALF(CH), .TICK_DIV(TD)) u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .key_i  (key),
    .ir_o   (ir_o),
    .busy_o (busy_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int burst_hi();
    int n = 0;
    for (int c = 0; c < 6 * TD; c++) if (((c / CH) % 2) == 0) n++;
    return n;
  endfunction

  function automatic int gap_tk(input bit b);
    return b ? 10 : 20;
  endfunction

  function automatic int frame_cycles(input logic [2:0] code);
    int t = 36 + 6 + 200;
    for (int i = 0; i < 3; i++) t += (6 + gap_tk(code[i])) + (6 + gap_tk(!code[i]));
    return t * TD;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pop_cmp(input int per);
    int ep, eh;
    if (per_q.size() == 0) begin
      check("R5 unexpected burst", 1, 0);
      return;
    end
    ep = per_q.pop_front();
    eh = hi_q.pop_front();
    if (ep != 0) check("R4/R5/R7 burst spacing", per, ep);
    check("R2 carrier high cycles", hi_cnt, eh);
  endtask

  // monitor: measure burst-to-burst spacing and high cycles per burst
  always @(negedge clk) begin
    if (flush_req) begin
      if (have_prev) pop_cmp(0);
      have_prev = 0;
      flush_req = 0;
    end
    if (ir_o && sil > 2 * CH) begin
      check("R10 busy during burst", int'(busy_o), 1);
      if (have_prev) pop_cmp(cyc - last_start);
      last_start = cyc;
      hi_cnt = 0;
      have_prev = 1;
      nstarts++;
    end
    if (ir_o) begin
      hi_cnt++;
      sil = 0;
    end else begin
      sil++;
    end
  end

  task automatic push_frames(input logic [2:0] code, input int frames);
    for (int f = 0; f < frames; f++) begin
      per_q.push_back(36 * TD); hi_q.push_back(burst_hi());
      for (int i = 0; i < 3; i++) begin
        per_q.push_back((6 + gap_tk(code[i])) * TD); hi_q.push_back(burst_hi());
      end
      for (int i = 0; i < 3; i++) begin
        per_q.push_back((6 + gap_tk(!code[i])) * TD); hi_q.push_back(burst_hi());
      end
      per_q.push_back((f < frames - 1) ? 206 * TD : 0); hi_q.push_back(burst_hi());
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_busy(input bit v);
    while (busy_o !== v) @(negedge clk);
  endtask

  task automatic finish_frames(input string req);
    wait_busy(1'b0);
    check(req, cyc, last_start + 206 * TD);
    flush_req = 1;
    wait (flush_req == 0);
    wait_n(40);
    check("R3 dark after frames", int'(ir_o), 0);
  endtask

  // R6 R7 R9: one key (or key set), held for 'frames' frames, released mid-frame
  task automatic run_key(input logic [3:0] keys, input logic [2:0] code, input int frames);
    push_frames(code, frames);
    key = keys;
    wait_busy(1'b1);
    wait_n((frames - 1) * frame_cycles(code) + 100);
    key = 4'b0000;
    finish_frames("R10 busy fall time (R9 release mid-frame)");
  endtask

  initial begin
    int n0;
    key   = 4'b0000;
    rst_n = 1'b0;
    wait_n(5);
    check("R1 ir_o in reset", int'(ir_o), 0);
    check("R1 busy_o in reset", int'(busy_o), 0);
    rst_n = 1'b1;
    wait_n(4);
    check("R1 ir_o after reset", int'(ir_o), 0);
    check("R1 busy_o after reset", int'(busy_o), 0);

    n0 = nstarts;
    wait_n(500);
    check("R11 no bursts without keys", nstarts, n0);
    check("R11 busy idle without keys", int'(busy_o), 0);

    run_key(4'b0001, 3'b001, 1);   // R6 key 0
    run_key(4'b0100, 3'b101, 2);   // R7 repeat, key 2
    run_key(4'b1010, 3'b100, 1);   // R6 priority key1 over key3
    run_key(4'b1000, 3'b111, 1);   // R6 key 3

    // R8: key 3 held, key 0 pressed mid-frame; repeats keep code 111
    push_frames(3'b111, 2);
    key = 4'b1000;
    wait_busy(1'b1);
    wait_n(1000);
    key = 4'b1001;
    wait_n(frame_cycles(3'b111));
    key = 4'b0001;
    wait_n(50);
    key = 4'b0000;
    finish_frames("R8 latched key ends repeats");
    check("R8 no leftover expected bursts", per_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #3000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule